// File: doc/BRIEF.md
# Power-Good Reset Timer

This block drives an active-low system reset from the "in regulation" flags of two supply rails, A and B. It keeps reset asserted (low) while the rails it watches are not all good. Once they are all good, it counts clock cycles and releases reset only after a fixed hold-off interval. The default interval is 32,000 cycles, which is about 107 ms at a 300 kHz clock and 160 ms at 200 kHz.

A two-bit sequencing code selects which rails are watched. In the separate-control mode only rail A matters. Every other code watches both rails. A shutdown input forces reset low. Whenever a watched rail drops out of regulation, or shutdown is raised, the count starts again from zero. The flags are assumed to be synchronous to the clock already. The comparators that produce them lie outside this block.

Top module: `pgood_reset_timer`

## Requirements
- R1: While the synchronous active-high `rst` is asserted, and on the first cycle after it, `sys_rst_n` is low and the hold-off count is zero.
- R2: With `seq_sel` = 2'b00 or 2'b10, both `rail_a_ok` and `rail_b_ok` must be high for a cycle to count. If either is low at a clock edge, `sys_rst_n` is low after that edge.
- R3: `sys_rst_n` goes high after exactly HOLD_CYCLES consecutive qualifying clock edges, and stays low until then. HOLD_CYCLES defaults to 32000.
- R4: With `seq_sel` = 2'b01, only `rail_a_ok` is watched. `rail_b_ok` has no effect on the count or on `sys_rst_n`.
- R5: If a watched rail is low at a clock edge, `sys_rst_n` is low after that edge and the count clears. After recovery, a full HOLD_CYCLES interval is needed again.
- R6: `shutdown` high at a clock edge drives `sys_rst_n` low after that edge and clears the count, whatever the rail flags are.
- R7: Once released, the count saturates. `sys_rst_n` stays high for as long as the conditions hold and never wraps back low.
- R8: The reserved code `seq_sel` = 2'b11 watches both rails, the same as 2'b00.
- R9: The rail selection is re-evaluated on every cycle. If `seq_sel` changes to a code that watches a rail which is currently bad, the count clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown | input | 1 | Forces the system reset active and clears the timer |
| seq_sel | input | 2 | Sequencing code: 00 and 10 watch both rails, 01 watches rail A only, 11 is reserved and watches both |
| rail_a_ok | input | 1 | Rail A is in regulation |
| rail_b_ok | input | 1 | Rail B is in regulation |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The hardest situations to reach are a drop-out one cycle before release and a change of the sequencing code in the middle of a count. Each needs the stimulus to line up exactly with the internal count. The bench builds the timer with a short hold-off interval so that whole intervals fit many times into one run. It then counts edges from each qualifying start and places rail drops, shutdown pulses and `seq_sel` changes at HOLD_CYCLES-1 and at mid-count. A behavioural count in the bench is compared against `sys_rst_n` on every cycle.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef enum logic [1:0] {
        SEQ_BOTH_LO  = 2'b00,
        SEQ_A_ONLY   = 2'b01,
        SEQ_BOTH_HI  = 2'b10,
        SEQ_RESERVED = 2'b11
    } seq_mode_e;

    typedef struct packed {
        logic a_ok;
        logic b_ok;
    } rail_flags_t;

    localparam int unsigned DEFAULT_HOLD = 32000;

    function automatic logic watch_b(input seq_mode_e mode);
        return (mode != SEQ_A_ONLY);
    endfunction

    function automatic logic rails_good(input seq_mode_e mode, input rail_flags_t f);
        return f.a_ok && (f.b_ok || !watch_b(mode));
    endfunction

endpackage

// File: rtl/pgr_qualifier.sv
module pgr_qualifier
    import pgr_pkg::*;
(
    input  logic        shutdown,
    input  seq_mode_e   mode,
    input  rail_flags_t flags,
    output logic        qualify
);

    always_comb begin
        qualify = !shutdown && rails_good(mode, flags);
    end

endmodule

// File: rtl/pgr_hold_counter.sv
module pgr_hold_counter #(
    parameter int unsigned HOLD = 32000
) (
    input  logic clk,
    input  logic rst,
    input  logic qualify,
    output logic done
);

    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] TERMINAL = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !qualify) begin
            cnt_q <= '0;
        end else if (cnt_q != TERMINAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == TERMINAL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done && qualify) |=> done); // R7

    AST_CLEAR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        !qualify |=> (cnt_q == '0)); // R5

    AST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TERMINAL); // R7

endmodule

// File: rtl/pgood_reset_timer.sv
module pgood_reset_timer
    import pgr_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = DEFAULT_HOLD
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shutdown,
    input  logic [1:0] seq_sel,
    input  logic       rail_a_ok,
    input  logic       rail_b_ok,
    output logic       sys_rst_n
);

    seq_mode_e   mode;
    rail_flags_t flags;
    logic        qualify;
    logic        done;

    assign mode  = seq_mode_e'(seq_sel);
    assign flags = '{a_ok: rail_a_ok, b_ok: rail_b_ok};

    pgr_qualifier u_qual (
        .shutdown (shutdown),
        .mode     (mode),
        .flags    (flags),
        .qualify  (qualify)
    );

    pgr_hold_counter #(.HOLD(HOLD_CYCLES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .qualify (qualify),
        .done    (done)
    );

    assign sys_rst_n = done;

    AST_SHDN_LOW: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> !sys_rst_n); // R6

    AST_RAIL_A_LOW: assert property (@(posedge clk) disable iff (rst)
        !rail_a_ok |=> !sys_rst_n); // R5

    AST_RAIL_B_WATCHED: assert property (@(posedge clk) disable iff (rst)
        (seq_sel != 2'b01 && !rail_b_ok) |=> !sys_rst_n); // R2

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !sys_rst_n); // R1

endmodule

// File: tb/test_pgood_reset_timer.sv
module test_pgood_reset_timer;

    localparam time PERIOD = 10ns;
    localparam int  HOLD   = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shutdown = 1'b0;
    logic [1:0] seq_sel = 2'b00;
    logic       rail_a_ok = 1'b0;
    logic       rail_b_ok = 1'b0;
    logic       sys_rst_n;

    int    checks = 0;
    int    errors = 0;
    int    mcount = 0;
    string tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    pgood_reset_timer #(.HOLD_CYCLES(HOLD)) i_pgood_reset_timer (
        .clk       (clk),
        .rst       (rst),
        .shutdown  (shutdown),
        .seq_sel   (seq_sel),
        .rail_a_ok (rail_a_ok),
        .rail_b_ok (rail_b_ok),
        .sys_rst_n (sys_rst_n)
    );

    function automatic bit model_good();
        if (seq_sel == 2'b01) return rail_a_ok;
        return rail_a_ok && rail_b_ok;
    endfunction

    always @(posedge clk) begin
        if (rst || shutdown || !model_good()) mcount <= 0;
        else if (mcount < HOLD) mcount <= mcount + 1;
    end

    task automatic check(input logic exp, input string t);
        checks++;
        if (sys_rst_n !== exp) begin
            errors++;
            $display("FAIL %s: sys_rst_n=%b expected=%b at %0t", t, sys_rst_n, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(mcount == HOLD, tag);
        end
    endtask

    task automatic set(input logic s, input logic [1:0] m, input logic a, input logic b);
        shutdown = s; seq_sel = m; rail_a_ok = a; rail_b_ok = b;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        set(1'b0, 2'b00, 1'b1, 1'b1);
        step(3);
        @(negedge clk); rst = 1'b0;
        check(1'b0, "R1");
        step(1);

        // R3: exact release, both rails good, mode 00
        tag = "R3";
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        step(HOLD - 1);
        check(1'b0, "R3");
        step(1);
        check(1'b1, "R3");

        // R7: saturation well past counter width
        tag = "R7";
        step(300);
        check(1'b1, "R7");

        // R5: drop rail A, full timeout repeats; drop at HOLD-1
        tag = "R5";
        rail_a_ok = 1'b0; step(1);
        check(1'b0, "R5");
        rail_a_ok = 1'b1; step(HOLD - 1);
        check(1'b0, "R5");
        rail_a_ok = 1'b0; step(1);
        rail_a_ok = 1'b1; step(HOLD);
        check(1'b1, "R5");

        // R2: rail B bad in both-rail modes
        tag = "R2";
        set(1'b0, 2'b10, 1'b1, 1'b0); step(HOLD + 5);
        check(1'b0, "R2");
        rail_b_ok = 1'b1; step(HOLD);
        check(1'b1, "R2");
        set(1'b0, 2'b00, 1'b0, 1'b1); step(10);

        // R4: rail A only, B toggling ignored
        tag = "R4";
        set(1'b0, 2'b01, 1'b1, 1'b0);
        for (int i = 0; i < HOLD + 20; i++) begin
            rail_b_ok = i[0];
            step(1);
        end
        check(1'b1, "R4");
        rail_b_ok = 1'b0; step(40);
        check(1'b1, "R4");

        // R9: switch to both-rail mode while B is bad
        tag = "R9";
        seq_sel = 2'b00; step(1);
        check(1'b0, "R9");
        seq_sel = 2'b01; step(HOLD / 2);
        seq_sel = 2'b10; step(1);
        seq_sel = 2'b01; step(HOLD);
        check(1'b1, "R9");

        // R6: shutdown forces low and clears
        tag = "R6";
        set(1'b1, 2'b00, 1'b1, 1'b1); step(1);
        check(1'b0, "R6");
        step(5);
        shutdown = 1'b0; step(HOLD - 1);
        check(1'b0, "R6");
        shutdown = 1'b1; step(1);
        shutdown = 1'b0; step(HOLD);
        check(1'b1, "R6");

        // R8: reserved code watches both rails
        tag = "R8";
        set(1'b0, 2'b11, 1'b1, 1'b0); step(HOLD + 5);
        check(1'b0, "R8");
        rail_b_ok = 1'b1; step(HOLD);
        check(1'b1, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule